// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit linear address into a 52-bit physical address. It reads a hierarchy of four translation tables from memory, one entry at a time. A translation request carries the linear address and two access attributes, write and user mode. The walker starts from the table base held in a root register. It takes a 9-bit index from the linear address for each level, fetches the 8-byte entry, and checks that entry's present, write and user flags. It then either moves to the next table or finishes. The response carries the physical address, or a fault code together with the level at which the walk stopped.

When paging is switched off, the walker returns the linear address, zero-extended, as the physical address. In that case it makes no memory access. Requests and responses use valid/ready handshakes, and so does the memory read-request channel. The read-response channel has valid only, because the walker always waits for the data it has asked for.

The back-pressure rules are as follows. A request is taken only on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the walker is idle. A response stays valid, with an unchanged payload, until `resp_ready` is seen high. A memory read request stays valid, with an unchanged address, until `mem_req_ready` is seen high. After that, no new read is raised until the data has returned.

Top module: `ptw_top`

## Requirements
- R1: With `paging_en` low, an accepted request answers on the next cycle. The answer is `resp_paddr` = the zero-extended linear address, `resp_fault` = 0 and `resp_level` = 0, and no memory read is issued.
- R2: The first read address is the root base (`root_base` bits 51:12, with its low 12 bits treated as zero) plus 8 times linear-address bits 47:39.
- R3: The remaining reads follow in the order level 3, level 2, level 1. They are indexed by linear-address bits 38:30, 29:21 and 20:12. Each read address is bits 51:12 of the previous entry, shifted left by 12, plus 8 times the index.
- R4: A walk with no fault makes exactly four reads. It returns `resp_paddr` = {last entry bits 51:12, linear bits 11:0}, with `resp_fault` = 0 and `resp_level` = 0.
- R5: If entry bit 0 (present) is clear, the walk stops with no further reads. It reports `resp_fault` = 1 and `resp_level` = the current level, from 4 for the top table down to 1 for the last table.
- R6: A write request needs entry bit 1 set, and a user request needs entry bit 2 set, at every level. The first level where a needed bit is clear ends the walk with `resp_fault` = 2 and that level. The present check takes priority over this check.
- R7: At most one memory read is outstanding. `mem_req_valid` stays high with a stable address until `mem_req_ready`, and drops for the cycle that follows a handshake.
- R8: `req_ready` is high only while idle. A request presented while a walk or a response is pending has no effect.
- R9: `resp_valid` and the whole response payload stay stable until `resp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| paging_en | input | 1 | High: translate; low: pass the address through |
| root_base | input | 52 | Physical base of the top-level table (bits 11:0 ignored) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 48 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response consumer ready |
| resp_paddr | output | 52 | Physical address (zero on fault) |
| resp_fault | output | 2 | 0 none, 1 not present, 2 protection |
| resp_level | output | 3 | Level that faulted (4..1), 0 otherwise |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 52 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry contents |

## Verification
The in-line assertions check the handshake rules on every cycle. They cover a stalled read request holding its address, the single outstanding read, a held response keeping its payload, and `req_ready` staying low while a response waits. They also check that a bypass answers at once without reading, and that fault levels lie in 1..4 while successful walks report level 0. Only the bench scenarios can show that the right entries are fetched in the right order, that the final address is assembled correctly, and that present and permission flags end the walk at the right level. To do this, the bench sweeps every faulting level against every flag combination and every write/user pairing.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PERM   = 2'd2
  } flt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_DONE
  } walk_st_e;

  localparam int unsigned BIT_PRESENT = 0;
  localparam int unsigned BIT_WRITE   = 1;
  localparam int unsigned BIT_USER    = 2;

endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
  parameter int unsigned VA_W   = 48,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned LEVELS = 4,
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] lvl_sel,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] fields [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_field
    assign fields[g] = vaddr[OFF_W + g*IDX_W +: IDX_W];
  end

  assign idx = fields[lvl_sel];

  logic unused_hi;
  assign unused_hi = ^vaddr[OFF_W-1:0];

endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int unsigned PA_W      = 52,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned IDX_W     = 9,
  parameter int unsigned ENT_BYTES = 8,
  localparam int unsigned BASE_W   = PA_W - OFF_W,
  localparam int unsigned ENT_SH   = $clog2(ENT_BYTES)
) (
  input  logic [BASE_W-1:0] tbl_base,
  input  logic [IDX_W-1:0]  idx,
  output logic [PA_W-1:0]   addr
);

  logic [PA_W-1:0] base_bytes;
  logic [PA_W-1:0] idx_bytes;

  assign base_bytes = {tbl_base, {OFF_W{1'b0}}};
  assign idx_bytes  = {{(PA_W-IDX_W-ENT_SH){1'b0}}, idx, {ENT_SH{1'b0}}};
  assign addr       = base_bytes + idx_bytes;

endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
#(
  parameter int unsigned ENT_W = 64,
  parameter int unsigned PA_W  = 52,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned BASE_W = PA_W - OFF_W
) (
  input  logic [ENT_W-1:0]  entry,
  input  logic              need_write,
  input  logic              need_user,
  output flt_e              fault,
  output logic [BASE_W-1:0] next_base
);

  logic present, wr_ok, us_ok;

  assign present   = entry[BIT_PRESENT];
  assign wr_ok     = entry[BIT_WRITE] | ~need_write;
  assign us_ok     = entry[BIT_USER]  | ~need_user;
  assign next_base = entry[PA_W-1:OFF_W];

  always_comb begin
    if (!present)               fault = FLT_ABSENT;
    else if (!(wr_ok && us_ok)) fault = FLT_PERM;
    else                        fault = FLT_NONE;
  end

  logic unused_bits;
  assign unused_bits = ^{entry[ENT_W-1:PA_W], entry[OFF_W-1:3]};

endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W      = 48,
  parameter int unsigned PA_W      = 52,
  parameter int unsigned IDX_W     = 9,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned LEVELS    = 4,
  parameter int unsigned ENT_W     = 64,
  parameter int unsigned ENT_BYTES = 8,
  localparam int unsigned BASE_W   = PA_W - OFF_W,
  localparam int unsigned LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int unsigned LNUM_W   = $clog2(LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              paging_en,
  input  logic [PA_W-1:0]   root_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [PA_W-1:0]   resp_paddr,
  output logic [1:0]        resp_fault,
  output logic [LNUM_W-1:0] resp_level,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data
);

  walk_st_e          st_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [BASE_W-1:0] base_q;
  logic [VA_W-1:0]   va_q;
  logic              wr_q, us_q;
  logic [PA_W-1:0]   pa_q;
  flt_e              flt_q;
  logic [LNUM_W-1:0] lnum_q;

  logic [IDX_W-1:0]  cur_idx;
  flt_e              chk_flt;
  logic [BASE_W-1:0] chk_base;

  ptw_index_sel #(
    .VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)
  ) u_idx (
    .vaddr(va_q), .lvl_sel(lvl_q), .idx(cur_idx)
  );

  ptw_entry_addr #(
    .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_BYTES(ENT_BYTES)
  ) u_addr (
    .tbl_base(base_q), .idx(cur_idx), .addr(mem_req_addr)
  );

  ptw_entry_check #(
    .ENT_W(ENT_W), .PA_W(PA_W), .OFF_W(OFF_W)
  ) u_chk (
    .entry(mem_rsp_data), .need_write(wr_q), .need_user(us_q),
    .fault(chk_flt), .next_base(chk_base)
  );

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_FETCH);
  assign resp_valid    = (st_q == ST_DONE);
  assign resp_paddr    = pa_q;
  assign resp_fault    = flt_q;
  assign resp_level    = lnum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lvl_q  <= '0;
      base_q <= '0;
      va_q   <= '0;
      wr_q   <= 1'b0;
      us_q   <= 1'b0;
      pa_q   <= '0;
      flt_q  <= FLT_NONE;
      lnum_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q <= req_vaddr;
            wr_q <= req_write;
            us_q <= req_user;
            if (!paging_en) begin
              pa_q   <= {{(PA_W-VA_W){1'b0}}, req_vaddr};
              flt_q  <= FLT_NONE;
              lnum_q <= '0;
              st_q   <= ST_DONE;
            end else begin
              base_q <= root_base[PA_W-1:OFF_W];
              lvl_q  <= LVL_W'(LEVELS - 1);
              st_q   <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (mem_req_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (chk_flt != FLT_NONE) begin
              pa_q   <= '0;
              flt_q  <= chk_flt;
              lnum_q <= LNUM_W'(lvl_q) + LNUM_W'(1);
              st_q   <= ST_DONE;
            end else if (lvl_q == '0) begin
              pa_q   <= {chk_base, va_q[OFF_W-1:0]};
              flt_q  <= FLT_NONE;
              lnum_q <= '0;
              st_q   <= ST_DONE;
            end else begin
              base_q <= chk_base;
              lvl_q  <= lvl_q - LVL_W'(1);
              st_q   <= ST_FETCH;
            end
          end
        end
        ST_DONE: begin
          if (resp_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic unused_root;
  assign unused_root = ^root_base[OFF_W-1:0];

  AST_BYPASS_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !paging_en) |=> (resp_valid && !mem_req_valid)); // R1
  AST_OK_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault == 2'd0) |-> (resp_level == '0)); // R4
  AST_FAULT_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault != 2'd0) |-> (resp_level >= LNUM_W'(1) && resp_level <= LNUM_W'(LEVELS))); // R5
  AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_fault != 2'd3)); // R6
  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R7
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready); // R8
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_paddr)
                                     && $stable(resp_fault) && $stable(resp_level))); // R9

endmodule

// File: tb/ptw_top_bench.sv
module ptw_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        paging_en = 1'b0;
  logic [51:0] root_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        resp_valid;
  logic        resp_ready = 1'b0;
  logic [51:0] resp_paddr;
  logic [1:0]  resp_fault;
  logic [2:0]  resp_level;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  ptw_top u_ptw_top (
    .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_paddr(resp_paddr),
    .resp_fault(resp_fault), .resp_level(resp_level),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int tests = 0;
  int fails = 0;
  int rd_cnt = 0;
  int overlap_viol = 0;
  int bad_step = 9;
  logic [2:0] bad_flags = 3'b111;
  bit stall_mode = 1'b0;
  logic [51:0] seen_addr [4];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] entry_of(input logic [51:0] a, input int s);
    logic [39:0] nb;
    logic [2:0]  fl;
    nb = a[51:12] * 40'd5 + {31'd0, a[11:3]} + 40'(s) + 40'd7;
    fl = (s == bad_step) ? bad_flags : 3'b111;
    return {12'hA5C, nb, 9'h16B, fl};
  endfunction

  // memory responder: one read at a time, optional request stall and data delay
  initial begin
    bit pend = 1'b0;
    int dly = 0;
    int sctr = 0;
    logic [51:0] pa = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      sctr++;
      mem_req_ready = stall_mode ? (sctr % 3 == 2) : 1'b1;
      if (pend) begin
        if (mem_req_valid) overlap_viol++;
        if (dly > 0) dly--;
        else begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = entry_of(pa, rd_cnt - 1);
          pend = 1'b0;
        end
      end else if (mem_req_valid && mem_req_ready) begin
        pend = 1'b1;
        pa   = mem_req_addr;
        dly  = stall_mode ? (sctr % 2) : 0;
        if (rd_cnt < 4) seen_addr[rd_cnt] = mem_req_addr;
        rd_cnt++;
      end
    end
  end

  task automatic do_walk(input logic [47:0] va, input logic [51:0] root, input bit w,
                         input bit u, input bit pg, input int hold, input bit poke);
    logic [51:0] exp_pa, a, cap_pa;
    logic [51:0] exp_a [4];
    logic [39:0] base;
    logic [63:0] e;
    logic [8:0]  idx;
    int exp_flt, exp_lvl, exp_rd;
    bit done;
    logic [1:0] cap_f;
    logic [2:0] cap_l;
    exp_pa = '0; exp_flt = 0; exp_lvl = 0; exp_rd = 0; done = 1'b0;
    for (int s = 0; s < 4; s++) exp_a[s] = '0;
    if (!pg) exp_pa = {4'h0, va};
    else begin
      base = root[51:12];
      for (int s = 0; s < 4; s++) begin
        if (!done) begin
          idx = va[47 - 9*s -: 9];
          a = {base, 12'h000} + {40'd0, idx, 3'b000};
          exp_a[s] = a;
          e = entry_of(a, s);
          exp_rd = s + 1;
          if (!e[0]) begin exp_flt = 1; exp_lvl = 4 - s; done = 1'b1; end
          else if ((w && !e[1]) || (u && !e[2])) begin exp_flt = 2; exp_lvl = 4 - s; done = 1'b1; end
          else begin
            base = e[51:12];
            if (s == 3) exp_pa = {base, va[11:0]};
          end
        end
      end
    end

    rd_cnt = 0; overlap_viol = 0;
    @(negedge clk);
    paging_en = pg; root_base = root; req_vaddr = va; req_write = w; req_user = u;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (poke) begin req_vaddr = ~va; req_write = ~w; end
    else req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    chk(req_ready == 1'b0, "R8 req_ready while response pending", 64'(req_ready), 64'd0);
    if (hold > 0) begin
      cap_pa = resp_paddr; cap_f = resp_fault; cap_l = resp_level;
      repeat (hold) @(negedge clk);
      chk(resp_valid && resp_paddr == cap_pa && resp_fault == cap_f && resp_level == cap_l,
          "R9 held response", {resp_valid, 9'd0, resp_paddr[51:0], resp_fault},
          {1'b1, 9'd0, cap_pa, cap_f});
    end
    chk(resp_paddr == exp_pa, pg ? "R4 physical address" : "R1 bypass address",
        64'(resp_paddr), 64'(exp_pa));
    chk(int'(resp_fault) == exp_flt, exp_flt == 2 ? "R6 fault code" : "R5 fault code",
        64'(resp_fault), 64'(exp_flt));
    chk(int'(resp_level) == exp_lvl, exp_flt == 2 ? "R6 fault level" : "R5 fault level",
        64'(resp_level), 64'(exp_lvl));
    chk(rd_cnt == exp_rd, pg ? "R5 read count" : "R1 no reads", 64'(rd_cnt), 64'(exp_rd));
    for (int s = 0; s < 4; s++)
      if (s < exp_rd && s < rd_cnt)
        chk(seen_addr[s] == exp_a[s], s == 0 ? "R2 first entry address" : "R3 entry address",
            64'(seen_addr[s]), 64'(exp_a[s]));
    chk(overlap_viol == 0, "R7 overlapping read", 64'(overlap_viol), 64'd0);
    resp_ready = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    resp_ready = 1'b0;
    chk(!resp_valid && req_ready && !mem_req_valid, "R8 idle after response, poke ignored",
        {61'd0, resp_valid, req_ready, mem_req_valid}, 64'b010);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k = 0;
    logic [47:0] va;
    logic [51:0] rt;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R8 reset req_ready", 64'(req_ready), 64'd1);
    chk(resp_valid == 1'b0, "R9 reset resp_valid", 64'(resp_valid), 64'd0);
    chk(mem_req_valid == 1'b0, "R7 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int b = 0; b < 4; b++) begin
      va = 48'h0123_4567_89AB * 48'(b + 1) ^ 48'hFFF0_0000_0FFF;
      do_walk(va, 52'hF_FFFF_FFFF_F000, b[0], b[1], 1'b0, b, b[0]); // R1
    end

    for (int bs = 0; bs < 5; bs++)
      for (int bf = 0; bf < 8; bf++)
        for (int wu = 0; wu < 4; wu++) begin
          k++;
          bad_step  = (bs == 4) ? 9 : bs;
          bad_flags = 3'(bf);
          stall_mode = k[2];
          va = (48'(k) * 48'h9E37_79B9_7F4A) ^ 48'h1234_5678_9ABC;
          rt = {40'(k) * 40'h00_0123_4567, 12'h5A5};
          do_walk(va, rt, wu[0], wu[1], 1'b1, k % 3, k[0]); // R2 R3 R4 R5 R6 R7
        end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule